// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the word a NOR-style flash places on its data bus while an internal program or erase algorithm is running, together with the ready/busy level. The surrounding command logic tells it what kind of operation is active, whether an erase is suspended, whether the current read address falls inside the sector under erase, and whether the operation has overrun its time limit. The block answers each host read with either a status word or the array data.

Status is not a static register. Two toggle bits flip at the end of every qualifying read, so a host polling in a loop sees consecutive reads differ for as long as the operation runs, and sees them settle once it finishes. A polarity bit carries the complement of the most significant bit of the programmed byte until completion. A sticky fault flag keeps the device in status output after a timeout until the block is reset.

Top module: `flash_status_gen`

## Requirements
- R1: After reset both toggle bits read 0, the fault flag is clear, `rdy_o` is 1 and an idle read returns `array_data_i` unchanged.
- R2: While a program runs (`busy_i`=1, `op_erase_i`=0), bit 7 of `dout_o` equals the inverse of `prog_msb_i` and `rdy_o` is 0.
- R3: Bit 6 flips at the end of every read, at any address, while `busy_i`=1 or the fault flag is set; the first such read after reset shows 0.
- R4: While an erase runs unsuspended, bit 7 reads 0 and bit 3 reads 1; during a program bit 3 reads 0.
- R5: During an unsuspended erase, bit 2 flips at the end of each read with `in_sector_i`=1 and holds its value across reads with `in_sector_i`=0.
- R6: With `susp_i`=1 and `busy_i`=0, `rdy_o` is 1; reads with `in_sector_i`=1 return status with bit 7 at 1, bit 6 frozen and bit 2 flipping per read, and reads with `in_sector_i`=0 return array data.
- R7: With `susp_i`=1 and `busy_i`=1 (program inside an erase suspend), bit 2 reads 1, bit 6 flips per read, bit 7 is the inverse of `prog_msb_i` and `rdy_o` is 0.
- R8: `timeout_i` during a running operation sets a sticky fault: bit 5 reads 1, `rdy_o` stays 0 and reads keep returning status after `busy_i` falls, until reset.
- R9: Once `busy_i` falls with no fault and no suspend, reads return the true array data and `rdy_o` is 1.
- R10: In every status word, bits 4, 1, 0 and all bits above bit 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears toggles and fault |
| busy_i | input | 1 | An embedded program or erase algorithm is running |
| op_erase_i | input | 1 | 1 = running operation is an erase, 0 = program |
| susp_i | input | 1 | Erase is suspended |
| in_sector_i | input | 1 | Read address lies in the sector being erased |
| timeout_i | input | 1 | Operation exceeded its internal time limit |
| prog_msb_i | input | 1 | Bit 7 of the latched program data |
| rd_i | input | 1 | Read strobe, high for the duration of a host read |
| array_data_i | input | DATA_W | Data from the array for the current address |
| dout_o | output | DATA_W | Word returned to the host |
| rdy_o | output | 1 | Ready (1) / busy (0) level |

## Verification
The bench builds the block with a 16-bit data word, which enables the generate branch that pads the status word above bit 7 and lets the tests drive array and program values with set upper bits to show those never leak into status. Directed scenarios walk program, erase, suspend-read, suspend-program, resume and timeout in one continuous run, so each toggle bit carries its history across mode changes and the expected parity after each read is known exactly.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

   // Operating view the word mux and ready logic decode from
   typedef enum logic [2:0] {
      MD_ARRAY     = 3'd0,   // idle: pass array data
      MD_RUN       = 3'd1,   // program or erase running
      MD_SUSP_PROG = 3'd2,   // program inside an erase suspend
      MD_SUSP_READ = 3'd3,   // erase suspended, no program
      MD_FAULT     = 3'd4    // time limit exceeded, sticky
   } stat_mode_e;

   // Bit positions inside the status byte
   localparam int unsigned B_POLL = 7;
   localparam int unsigned B_TGL  = 6;
   localparam int unsigned B_TMO  = 5;
   localparam int unsigned B_ERS  = 3;
   localparam int unsigned B_SEC  = 2;
   localparam int unsigned STAT_W = 8;

endpackage

// File: rtl/fsg_mode_dec.sv
module fsg_mode_dec
   import flash_stat_pkg::*;
(
   input  logic       busy_i,
   input  logic       susp_i,
   input  logic       fault_i,
   output stat_mode_e mode_o,
   output logic       rdy_o
);

   always_comb begin
      if (fault_i)              mode_o = MD_FAULT;
      else if (busy_i && susp_i) mode_o = MD_SUSP_PROG;
      else if (busy_i)           mode_o = MD_RUN;
      else if (susp_i)           mode_o = MD_SUSP_READ;
      else                       mode_o = MD_ARRAY;
   end

   assign rdy_o = (mode_o == MD_ARRAY) || (mode_o == MD_SUSP_READ);

endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_end_i,
   input  logic en_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q_o <= INIT;
      else if (rd_end_i && en_i) q_o <= ~q_o;
   end

endmodule

// File: rtl/fsg_word.sv
module fsg_word
   import flash_stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  stat_mode_e          mode_i,
   input  logic                op_erase_i,
   input  logic                susp_i,
   input  logic                in_sector_i,
   input  logic                timeout_i,
   input  logic                prog_msb_i,
   input  logic                t6_i,
   input  logic                t2_i,
   input  logic [DATA_W-1:0]   array_data_i,
   output logic [DATA_W-1:0]   dout_o
);

   localparam int unsigned PAD_W = DATA_W - STAT_W;

   logic [STAT_W-1:0] stat;
   logic              show_stat;
   logic [DATA_W-1:0] stat_w;

   always_comb begin
      stat      = '0;
      show_stat = 1'b1;
      unique case (mode_i)
         MD_RUN: begin
            stat[B_POLL] = op_erase_i ? 1'b0 : ~prog_msb_i;
            stat[B_TGL]  = t6_i;
            stat[B_TMO]  = timeout_i;
            stat[B_ERS]  = op_erase_i;
            stat[B_SEC]  = t2_i;
         end
         MD_SUSP_PROG: begin
            stat[B_POLL] = ~prog_msb_i;
            stat[B_TGL]  = t6_i;
            stat[B_TMO]  = timeout_i;
            stat[B_SEC]  = 1'b1;
         end
         MD_SUSP_READ: begin
            stat[B_POLL] = 1'b1;
            stat[B_TGL]  = t6_i;
            stat[B_SEC]  = t2_i;
            show_stat    = in_sector_i;
         end
         MD_FAULT: begin
            stat[B_POLL] = op_erase_i ? 1'b0 : ~prog_msb_i;
            stat[B_TGL]  = t6_i;
            stat[B_TMO]  = 1'b1;
            stat[B_ERS]  = op_erase_i;
            stat[B_SEC]  = susp_i ? 1'b1 : t2_i;
         end
         default: show_stat = 1'b0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign stat_w = {{PAD_W{1'b0}}, stat};
      end else begin : g_exact
         assign stat_w = stat;
      end
   endgenerate

   assign dout_o = show_stat ? stat_w : array_data_i;

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
   import flash_stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_erase_i,
   input  logic              susp_i,
   input  logic              in_sector_i,
   input  logic              timeout_i,
   input  logic              prog_msb_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] array_data_i,
   output logic [DATA_W-1:0] dout_o,
   output logic              rdy_o
);

   generate
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("flash_status_gen: DATA_W must be at least 8");
      end
   endgenerate

   stat_mode_e mode;
   logic       rd_q;
   logic       rd_end;
   logic       fault_q;
   logic       t6, t2;
   logic       t6_en, t2_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         rd_q <= rd_i;
         if (busy_i && timeout_i) fault_q <= 1'b1;
      end
   end

   assign rd_end = rd_q & ~rd_i;

   fsg_mode_dec u_dec (
      .busy_i  (busy_i),
      .susp_i  (susp_i),
      .fault_i (fault_q),
      .mode_o  (mode),
      .rdy_o   (rdy_o)
   );

   assign t6_en = (mode == MD_RUN) || (mode == MD_SUSP_PROG) || (mode == MD_FAULT);
   assign t2_en = in_sector_i &&
                  ((mode == MD_SUSP_READ) || ((mode == MD_RUN) && op_erase_i));

   fsg_toggle #(.INIT(1'b0)) u_t6 (
      .clk(clk), .rst_n(rst_n), .rd_end_i(rd_end), .en_i(t6_en), .q_o(t6)
   );

   fsg_toggle #(.INIT(1'b0)) u_t2 (
      .clk(clk), .rst_n(rst_n), .rd_end_i(rd_end), .en_i(t2_en), .q_o(t2)
   );

   fsg_word #(.DATA_W(DATA_W)) u_word (
      .mode_i       (mode),
      .op_erase_i   (op_erase_i),
      .susp_i       (susp_i),
      .in_sector_i  (in_sector_i),
      .timeout_i    (timeout_i),
      .prog_msb_i   (prog_msb_i),
      .t6_i         (t6),
      .t2_i         (t2),
      .array_data_i (array_data_i),
      .dout_o       (dout_o)
   );

endmodule

// File: rtl/fsg_chk.sv
module fsg_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              op_erase_i,
   input logic              susp_i,
   input logic              in_sector_i,
   input logic              timeout_i,
   input logic              prog_msb_i,
   input logic [DATA_W-1:0] array_data_i,
   input logic [DATA_W-1:0] dout_o,
   input logic              rdy_o
);

   // R2
   poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !op_erase_i) |-> (dout_o[7] == ~prog_msb_i));

   // R6
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> !busy_i);

   // R9
   array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_o && !susp_i) |-> (dout_o == array_data_i));

   // R6
   susp_tgl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_o && susp_i && in_sector_i && $past(rdy_o && susp_i && in_sector_i))
         |-> $stable(dout_o[6]));

   // R7
   susp_prog_q2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && susp_i) |-> dout_o[2]);

   // R8
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_i && timeout_i) |-> (!rdy_o && dout_o[5]));

   // R10
   spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy_o |-> (dout_o[4] == 1'b0 && dout_o[1:0] == 2'b00
                  && (dout_o >> 8) == '0));

endmodule

bind flash_status_gen fsg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_i       (busy_i),
   .op_erase_i   (op_erase_i),
   .susp_i       (susp_i),
   .in_sector_i  (in_sector_i),
   .timeout_i    (timeout_i),
   .prog_msb_i   (prog_msb_i),
   .array_data_i (array_data_i),
   .dout_o       (dout_o),
   .rdy_o        (rdy_o)
);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;

   localparam int unsigned DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          busy_i = 1'b0, op_erase_i = 1'b0, susp_i = 1'b0;
   logic          in_sector_i = 1'b0, timeout_i = 1'b0, prog_msb_i = 1'b0;
   logic          rd_i = 1'b0;
   logic [DW-1:0] array_data_i = '0;
   logic [DW-1:0] dout_o;
   logic          rdy_o;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   flash_status_gen #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .op_erase_i(op_erase_i),
      .susp_i(susp_i), .in_sector_i(in_sector_i), .timeout_i(timeout_i),
      .prog_msb_i(prog_msb_i), .rd_i(rd_i), .array_data_i(array_data_i),
      .dout_o(dout_o), .rdy_o(rdy_o)
   );

   task automatic check(input string req, input logic [DW-1:0] got,
                        input logic [DW-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // one host read: strobe high one cycle, sample, release, let the flip land
   task automatic host_read(input string req, input logic [DW-1:0] exp);
      @(negedge clk) rd_i = 1'b1;
      @(negedge clk);
      check(req, dout_o, exp);
      rd_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      busy_i = 0; op_erase_i = 0; susp_i = 0; in_sector_i = 0;
      timeout_i = 0; prog_msb_i = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      array_data_i = 16'hA55A;
      @(negedge clk);
      check("R1 rdy", {15'd0, rdy_o}, 16'd1);
      host_read("R1 idle read", 16'hA55A);
   endtask

   task automatic t_program();
      @(negedge clk) busy_i = 1; op_erase_i = 0; prog_msb_i = 1;
      array_data_i = 16'hFFFF;
      @(negedge clk);
      check("R2 rdy low", {15'd0, rdy_o}, 16'd0);
      host_read("R2 R3 R4 first read", 16'h0000);
      host_read("R3 second read flips", 16'h0040);
      repeat (5) @(negedge clk);
      host_read("R3 third read", 16'h0000);
      prog_msb_i = 0;
      host_read("R2 R10 inverted msb", 16'h00C0);
      @(negedge clk) busy_i = 0; array_data_i = 16'h1234;
      @(negedge clk);
      check("R9 rdy high", {15'd0, rdy_o}, 16'd1);
      host_read("R9 true data", 16'h1234);
   endtask

   task automatic t_erase();
      @(negedge clk) busy_i = 1; op_erase_i = 1; in_sector_i = 1;
      host_read("R4 R5 erase read 1", 16'h0008);
      host_read("R5 erase read 2", 16'h004C);
      in_sector_i = 0;
      host_read("R5 outside sector hold", 16'h0008);
      host_read("R3 R5 outside sector", 16'h0048);
   endtask

   task automatic t_susp_read();
      @(negedge clk) busy_i = 0; susp_i = 1; in_sector_i = 1;
      array_data_i = 16'hBEEF;
      @(negedge clk);
      check("R6 rdy high", {15'd0, rdy_o}, 16'd1);
      host_read("R6 sector read 1", 16'h0080);
      host_read("R6 sector read 2", 16'h0084);
      in_sector_i = 0;
      host_read("R6 other sector", 16'hBEEF);
   endtask

   task automatic t_susp_prog();
      @(negedge clk) busy_i = 1; op_erase_i = 0; prog_msb_i = 1;
      @(negedge clk);
      check("R7 rdy low", {15'd0, rdy_o}, 16'd0);
      host_read("R7 read 1", 16'h0004);
      host_read("R7 read 2", 16'h0044);
   endtask

   task automatic t_timeout();
      @(negedge clk) susp_i = 0; op_erase_i = 1; in_sector_i = 1;
      host_read("R5 resumed erase", 16'h0008);
      @(negedge clk) timeout_i = 1;
      host_read("R8 timeout status", 16'h006C);
      @(negedge clk) busy_i = 0; timeout_i = 0; array_data_i = 16'h7777;
      @(negedge clk);
      check("R8 rdy stays low", {15'd0, rdy_o}, 16'd0);
      host_read("R8 sticky status", 16'h002C);
      do_reset();
      check("R1 R8 rdy after reset", {15'd0, rdy_o}, 16'd1);
      host_read("R1 R8 array after reset", 16'h7777);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_program();
      t_erase();
      t_susp_read();
      t_susp_prog();
      t_timeout();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule